// File: doc/BRIEF.md
# Sign-Conditioned Jump Control Unit

This block sits beside the microsequencer of a bit-serial computer. It decides whether a conditional jump is taken. It lets the jump finish in the same microcycle that streams the accumulator through the ALU. While the word passes, a sign flip-flop samples the ALU sign output at the most significant bit time.

A condition-select field then tests that flip-flop for clear or for set. Undefined condition codes always read as false.

For an ordinary microinstruction, a true test raises the microcode branch output. A jump microinstruction blocks that branch. Instead it raises a program-counter load strobe at the final bit time, and the program counter takes the instruction's address field on the clock edge that closes the microcycle. The "jump if accumulator non-negative" opcode uses the clear test, and the "jump if negative" opcode uses the set test. Both are single microinstructions with no unconditional form.

Top module: `sjmp_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and the sign flip-flop is 0. The flip-flop value is seen through cond_i = 3'b110 with a non-jump misc_i, which gives branch_o = 1.
- R2: The sign flip-flop loads alu_sign_i on a rising clk_i edge only when bit_time_i equals 16. At every other bit time it holds its value.
- R3: Condition code 3'b110 is true when the sign flip-flop is 0. Code 3'b001 is true when it is 1. Every other cond_i value is false.
- R4: When misc_i is not 3'b010, branch_o equals the condition result combinationally, and pc_load_o is 0.
- R5: When misc_i is 3'b010 (jump), branch_o is 0 whatever the condition.
- R6: pc_load_o is 1 exactly when misc_i is 3'b010, the condition is true, and bit_time_i equals 17.
- R7: On a rising clk_i edge with pc_load_o high, pc_o takes addr_i (10 bits). On any other edge pc_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| misc_i | input | 3 | Microinstruction misc field; 3'b010 selects jump |
| cond_i | input | 3 | Condition-select field |
| alu_sign_i | input | 1 | ALU sign output for the current serial bit |
| bit_time_i | input | 5 | Bit time within the microcycle, 0 to 17 |
| addr_i | input | 10 | Address field of the instruction register |
| branch_o | output | 1 | Microcode branch taken |
| pc_load_o | output | 1 | Program-counter load strobe |
| pc_o | output | 10 | Program counter |

## Verification
branch_o and pc_load_o are combinational, so they are due in the same cycle as their inputs. The bench drives on the falling edge and compares them a short delay later, before the next rising edge.

A value sampled by the sign flip-flop at T16 first affects these outputs in the following cycle. The bench model updates its own sign copy only at the rising edge.

pc_o is due one rising edge after the cycle in which the strobe was high. It is compared just after that edge against a model program counter updated at the same edge.

// File: rtl/sjmp_pkg.sv
package sjmp_pkg;
  localparam logic [2:0] MISC_JUMP    = 3'b010;
  localparam logic [2:0] COND_SGN_CLR = 3'b110;
  localparam logic [2:0] COND_SGN_SET = 3'b001;
endpackage

// File: rtl/sjmp_sign_ff.sv
module sjmp_sign_ff #(
  parameter int BT_W    = 5,
  parameter int SIGN_BT = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [BT_W-1:0] bit_time_i,
  input  logic            alu_sign_i,
  output logic            sign_o
);
  logic cap;
  assign cap = (bit_time_i == BT_W'(SIGN_BT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  sign_o <= 1'b0;
    else if (cap) sign_o <= alu_sign_i;
  end
endmodule

// File: rtl/sjmp_cond.sv
module sjmp_cond
  import sjmp_pkg::*;
(
  input  logic [2:0] misc_i,
  input  logic [2:0] cond_i,
  input  logic       sign_i,
  input  logic       at_load_i,
  output logic       branch_o,
  output logic       pc_load_o
);
  logic cond_true;
  logic is_jump;

  always_comb begin
    case (cond_i)
      COND_SGN_CLR: cond_true = ~sign_i;
      COND_SGN_SET: cond_true = sign_i;
      default:      cond_true = 1'b0;
    endcase
  end

  assign is_jump   = (misc_i == MISC_JUMP);
  // jump suppresses the microcode branch and retargets the test to the PC
  assign branch_o  = cond_true & ~is_jump;
  assign pc_load_o = cond_true & is_jump & at_load_i;
endmodule

// File: rtl/sjmp_pc.sv
module sjmp_pc #(
  parameter int PC_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [PC_W-1:0] addr_i,
  output logic [PC_W-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_o <= '0;
    else if (load_i) pc_o <= addr_i;
  end
endmodule

// File: rtl/sjmp_unit.sv
module sjmp_unit #(
  parameter int PC_W    = 10,
  parameter int SIGN_BT = 16,
  parameter int LOAD_BT = 17,
  localparam int BT_W   = $clog2(LOAD_BT + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2:0]      misc_i,
  input  logic [2:0]      cond_i,
  input  logic            alu_sign_i,
  input  logic [BT_W-1:0] bit_time_i,
  input  logic [PC_W-1:0] addr_i,
  output logic            branch_o,
  output logic            pc_load_o,
  output logic [PC_W-1:0] pc_o
);
  logic sign_q;
  logic at_load;

  assign at_load = (bit_time_i == BT_W'(LOAD_BT));

  sjmp_sign_ff #(.BT_W(BT_W), .SIGN_BT(SIGN_BT)) u_sign (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_time_i (bit_time_i),
    .alu_sign_i (alu_sign_i),
    .sign_o     (sign_q)
  );

  sjmp_cond u_cond (
    .misc_i    (misc_i),
    .cond_i    (cond_i),
    .sign_i    (sign_q),
    .at_load_i (at_load),
    .branch_o  (branch_o),
    .pc_load_o (pc_load_o)
  );

  sjmp_pc #(.PC_W(PC_W)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pc_load_o),
    .addr_i (addr_i),
    .pc_o   (pc_o)
  );
endmodule

// File: rtl/sjmp_unit_chk.sv
module sjmp_unit_chk
  import sjmp_pkg::*;
#(
  parameter int PC_W    = 10,
  parameter int SIGN_BT = 16,
  parameter int LOAD_BT = 17,
  parameter int BT_W    = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [2:0]      misc_i,
  input logic [2:0]      cond_i,
  input logic [BT_W-1:0] bit_time_i,
  input logic [PC_W-1:0] addr_i,
  input logic            branch_o,
  input logic            pc_load_o,
  input logic [PC_W-1:0] pc_o,
  input logic            sign_q
);
  // R2
  sign_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_time_i != BT_W'(SIGN_BT)) |=> $stable(sign_q));
  // R3
  branch_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_o |-> (cond_i == COND_SGN_CLR || cond_i == COND_SGN_SET));
  // R5
  jump_no_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (misc_i == MISC_JUMP) |-> !branch_o);
  // R6
  load_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> (misc_i == MISC_JUMP && bit_time_i == BT_W'(LOAD_BT)));
  // R7
  pc_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> (pc_o == $past(addr_i)));
  // R7
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_load_o |=> $stable(pc_o));
endmodule

bind sjmp_unit sjmp_unit_chk #(
  .PC_W(PC_W), .SIGN_BT(SIGN_BT), .LOAD_BT(LOAD_BT), .BT_W(BT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .misc_i     (misc_i),
  .cond_i     (cond_i),
  .bit_time_i (bit_time_i),
  .addr_i     (addr_i),
  .branch_o   (branch_o),
  .pc_load_o  (pc_load_o),
  .pc_o       (pc_o),
  .sign_q     (sign_q)
);

// File: tb/sim_sjmp_unit.sv
`timescale 1ns/1ps
module sim_sjmp_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] misc = 3'b000;
  logic [2:0] cond = 3'b000;
  logic       asign = 1'b0;
  logic [4:0] bt = 5'd0;
  logic [9:0] addr = 10'd0;
  logic       branch, pc_load;
  logic [9:0] pc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic       sign_m = 1'b0;
  logic [9:0] pc_m = 10'd0;

  always #10 clk = ~clk;

  sjmp_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .misc_i(misc), .cond_i(cond),
    .alu_sign_i(asign), .bit_time_i(bt), .addr_i(addr),
    .branch_o(branch), .pc_load_o(pc_load), .pc_o(pc)
  );

  function automatic logic f_cond(input logic [2:0] c, input logic s);
    if (c == 3'b110) return !s;
    if (c == 3'b001) return s;
    return 1'b0;
  endfunction

  function automatic logic f_branch(input logic [2:0] m, input logic [2:0] c, input logic s);
    return (m != 3'b010) && f_cond(c, s);
  endfunction

  function automatic logic f_load(input logic [2:0] m, input logic [2:0] c,
                                  input logic s, input logic [4:0] t);
    return (m == 3'b010) && f_cond(c, s) && (t == 5'd17);
  endfunction

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; leaves at the next falling edge
  task automatic step(input logic [2:0] m, input logic [2:0] c, input logic s,
                      input logic [4:0] t, input logic [9:0] a, input string tag);
    logic eb, el;
    misc = m; cond = c; asign = s; bt = t; addr = a;
    #2;
    eb = f_branch(m, c, sign_m);
    el = f_load(m, c, sign_m, t);
    check({tag, " R4 branch"}, {9'd0, branch}, {9'd0, eb});
    if (m == 3'b010) check("R5 branch under jump", {9'd0, branch}, 10'd0);
    check({tag, " R6 load"}, {9'd0, pc_load}, {9'd0, el});
    @(posedge clk);
    if (t == 5'd16) sign_m = s;
    if (el) pc_m = a;
    #2;
    check({tag, " R7 pc"}, pc, pc_m);
    @(negedge clk);
  endtask

  task automatic cycle_run(input logic [2:0] m, input logic [2:0] c, input logic s,
                           input logic [9:0] a, input string tag);
    for (int t = 0; t < 18; t++)
      step(m, c, (t == 16) ? s : 1'b0, 5'(t), a, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #5;
    // R1: reset state
    cond = 3'b110;
    #2;
    check("R1 pc", pc, 10'd0);
    check("R1 sign clear", {9'd0, branch}, 10'd1);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // E-style: jump if non-negative, sign 0 -> taken
    cycle_run(3'b010, 3'b110, 1'b0, 10'h155, "E taken");
    check("R7 E target", pc, 10'h155);
    // G-style: jump if negative, sign 0 -> not taken
    cycle_run(3'b010, 3'b001, 1'b0, 10'h2aa, "G not taken");
    check("R7 G hold", pc, 10'h155);
    // G-style with sign 1 -> taken
    cycle_run(3'b010, 3'b001, 1'b1, 10'h3c3, "G taken");
    check("R7 G target", pc, 10'h3c3);
    // E-style with sign 1 -> not taken
    cycle_run(3'b010, 3'b110, 1'b1, 10'h001, "E not taken");
    check("R7 E hold", pc, 10'h3c3);

    // R2: sign input at a non-sampling bit time is ignored (sign_m is 1 now)
    step(3'b000, 3'b000, 1'b0, 5'd5, 10'd0, "R2 off-time");
    step(3'b000, 3'b001, 1'b0, 5'd6, 10'd0, "R2 held");
    check("R2 sign kept", {9'd0, branch}, 10'd1);
    // R3: undefined code with either sign value is false
    step(3'b000, 3'b011, 1'b0, 5'd7, 10'd0, "R3 undefined");
    check("R3 undefined code", {9'd0, branch}, 10'd0);
    step(3'b010, 3'b111, 1'b0, 5'd17, 10'h0ff, "R3 undefined jump");
    check("R3 no load", pc, 10'h3c3);
    // R4: non-jump misc at T17 with true condition gives branch, no load
    step(3'b011, 3'b001, 1'b0, 5'd17, 10'h0f0, "R4 nonjump T17");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] m, c;
      logic [4:0] t;
      m = ($urandom % 2) ? 3'b010 : 3'($urandom);
      case ($urandom % 4)
        0: c = 3'b110;
        1: c = 3'b001;
        default: c = 3'($urandom);
      endcase
      case ($urandom % 3)
        0: t = 5'd16;
        1: t = 5'd17;
        default: t = 5'($urandom % 18);
      endcase
      step(m, c, 1'($urandom), t, 10'($urandom), "rand");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule